// File: doc/BRIEF.md
# Packed Wide-Write Narrow-Read Buffer

This buffer accepts 96-bit records on a write port and serves 32-bit words on a random-access read port. Each record holds three 32-bit sub-words (sub-word 0 in bits 31:0, sub-word 1 in bits 63:32, sub-word 2 in bits 95:64). Storage is a 64-bit-wide array with separate write enables for its lower half (bits 31:0) and upper half (bits 63:32). Records are packed densely: record `a` starts at row `(3*a)/2`, so a pair of records fills exactly three rows and no storage is left unused.

A record needs two row writes, so it takes two clock cycles. The write port takes a request when `wr_req` is high and `wr_busy` is low, and raises `wr_busy` for the following cycle, which is the second write cycle. The read port takes a flat word index `k = 3*a + s`. The word is held in row `k/2`, in the lower half when `k` is even and in the upper half when `k` is odd. Read data comes out one cycle after the request, together with a valid strobe.

Top module: `packed_wide_buffer`

## Requirements
- R1: A write request is accepted only when `wr_busy` is low. `wr_busy` is high for exactly the one cycle after an accepted request. A request presented while `wr_busy` is high is ignored and changes no stored data.
- R2: An even record address `a` writes sub-words 0 and 1 to the lower and upper halves of row `3*a/2` in the accept cycle. It writes sub-word 2 to the lower half of the next row in the second cycle.
- R3: An odd record address `a` writes sub-word 0 to the upper half of row `(3*a)/2` in the accept cycle. It writes sub-words 1 and 2 to the lower and upper halves of the next row in the second cycle.
- R4: A read of index `k`, for `k < 3*2^WADDR_W`, returns sub-word `k%3` of the record most recently written at address `k/3`.
- R5: A half-row write leaves the other half of that row unchanged, so neighbouring even and odd records never corrupt each other.
- R6: A read request at a clock edge produces `rd_valid` high and the data after that same edge. `rd_valid` is low after an edge with no read request.
- R7: A read of a word in the same cycle that the word is being written returns the value stored before that write.
- R8: A read with an index of `3*2^WADDR_W` or more returns zero with `rd_valid` high.
- R9: During reset, `wr_busy`, `rd_valid` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request |
| wr_addr | input | WADDR_W | Record address |
| wr_data | input | 3*SUB_W | Record data, sub-word 0 in the low bits |
| wr_busy | output | 1 | Second write cycle in progress, requests ignored |
| rd_req | input | 1 | Read request |
| rd_idx | input | RIDX_W | Flat word index |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | SUB_W | Read word |

## Verification
The hardest case to reach is a read that hits a half-row in the very cycle the write sequencer updates it, either the accept cycle or the second cycle. It also has to be told apart from a straddling record whose neighbour shares the row. Directed sequences line up a write request and a read of sub-word 0, and then of sub-word 2, on consecutive edges. This is done for both an even and an odd address. A held write request across the busy cycle checks that the request is dropped. Random stimulus then mixes writes and reads over the whole index range against a record-level model.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // First storage row of record a in the dense packing
  function automatic logic [31:0] rec_first_row(input logic [31:0] a);
    return (a * 32'd3) >> 1;
  endfunction

  // Row holding flat word index k
  function automatic logic [31:0] word_row(input logic [31:0] k);
    return k >> 1;
  endfunction

  // Half (0 lower, 1 upper) holding flat word index k
  function automatic logic word_half(input logic [31:0] k);
    return k[0];
  endfunction
endpackage

// File: rtl/pwb_write_seq.sv
module pwb_write_seq #(
  parameter int SUB_W   = 32,
  parameter int WADDR_W = 6,
  parameter int ROW_W   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic [WADDR_W-1:0]   wr_addr,
  input  logic [3*SUB_W-1:0]   wr_data,
  output logic                 busy,
  output logic                 accept,
  output logic [ROW_W-1:0]     row,
  output logic [2*SUB_W-1:0]   row_data,
  output logic                 we_lo,
  output logic                 we_hi
);
  import pwb_pkg::*;

  logic               busy_q, odd_q;
  logic [ROW_W-1:0]   row2_q;
  logic [2*SUB_W-1:0] hold_q;
  logic [SUB_W-1:0]   sw0, sw1, sw2;
  logic [ROW_W-1:0]   base_row;

  assign sw0      = wr_data[SUB_W-1:0];
  assign sw1      = wr_data[2*SUB_W-1:SUB_W];
  assign sw2      = wr_data[3*SUB_W-1:2*SUB_W];
  assign base_row = ROW_W'(rec_first_row(32'(wr_addr)));
  assign accept   = wr_req & ~busy_q;
  assign busy     = busy_q;

  always_comb begin
    row      = '0;
    row_data = '0;
    we_lo    = 1'b0;
    we_hi    = 1'b0;
    if (accept) begin
      row = base_row;
      if (wr_addr[0]) begin
        row_data = {sw0, sw0};
        we_hi    = 1'b1;
      end else begin
        row_data = {sw1, sw0};
        we_lo    = 1'b1;
        we_hi    = 1'b1;
      end
    end else if (busy_q) begin
      row      = row2_q;
      row_data = hold_q;
      we_lo    = 1'b1;
      we_hi    = odd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      odd_q  <= 1'b0;
      row2_q <= '0;
      hold_q <= '0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        odd_q  <= wr_addr[0];
        row2_q <= base_row + ROW_W'(1);
        hold_q <= wr_addr[0] ? {sw2, sw1} : {sw2, sw2};
      end
    end
  end
endmodule

// File: rtl/pwb_dense_array.sv
module pwb_dense_array #(
  parameter int SUB_W = 32,
  parameter int ROWS  = 96,
  parameter int ROW_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_lo,
  input  logic               we_hi,
  input  logic [ROW_W-1:0]   wr_row,
  input  logic [2*SUB_W-1:0] wr_data,
  input  logic               rd_en,
  input  logic [ROW_W-1:0]   rd_row,
  output logic [2*SUB_W-1:0] rd_q
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [SUB_W-1:0] mem [ROWS];
    logic [SUB_W-1:0] q;
    logic             we_b;

    assign we_b = (b == 0) ? we_lo : we_hi;

    always_ff @(posedge clk) begin
      if (we_b) mem[wr_row] <= wr_data[b*SUB_W +: SUB_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (rd_en) q <= mem[rd_row];
    end

    assign rd_q[b*SUB_W +: SUB_W] = q;
  end
endmodule

// File: rtl/packed_wide_buffer.sv
module packed_wide_buffer #(
  parameter int SUB_W   = 32,
  parameter int WADDR_W = 6,
  localparam int NREC   = 2 ** WADDR_W,
  localparam int NWORDS = 3 * NREC,
  localparam int ROWS   = NWORDS / 2,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int RIDX_W = $clog2(NWORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic [WADDR_W-1:0]   wr_addr,
  input  logic [3*SUB_W-1:0]   wr_data,
  output logic                 wr_busy,
  input  logic                 rd_req,
  input  logic [RIDX_W-1:0]    rd_idx,
  output logic                 rd_valid,
  output logic [SUB_W-1:0]     rd_data
);
  import pwb_pkg::*;

  // Named internal events, observed by the bound checker
  logic               accept;
  logic               we_lo, we_hi;
  logic [ROW_W-1:0]   wr_row;
  logic [2*SUB_W-1:0] wr_row_data;
  logic               rd_inrange, rd_en;
  logic [ROW_W-1:0]   rd_row;
  logic [2*SUB_W-1:0] rd_q;
  logic               valid_q, half_q, inr_q;

  pwb_write_seq #(.SUB_W(SUB_W), .WADDR_W(WADDR_W), .ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(wr_busy), .accept(accept), .row(wr_row),
    .row_data(wr_row_data), .we_lo(we_lo), .we_hi(we_hi)
  );

  assign rd_inrange = 32'(rd_idx) < 32'(NWORDS);
  assign rd_en      = rd_req & rd_inrange;
  assign rd_row     = ROW_W'(word_row(32'(rd_idx)));

  pwb_dense_array #(.SUB_W(SUB_W), .ROWS(ROWS), .ROW_W(ROW_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we_lo(we_lo), .we_hi(we_hi),
    .wr_row(wr_row), .wr_data(wr_row_data), .rd_en(rd_en),
    .rd_row(rd_row), .rd_q(rd_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      half_q  <= 1'b0;
      inr_q   <= 1'b0;
    end else begin
      valid_q <= rd_req;
      if (rd_req) begin
        half_q <= word_half(32'(rd_idx));
        inr_q  <= rd_inrange;
      end
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = !inr_q ? '0 : (half_q ? rd_q[2*SUB_W-1:SUB_W] : rd_q[SUB_W-1:0]);
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int WADDR_W = 6,
  parameter int ROW_W   = 7,
  parameter int RIDX_W  = 8,
  parameter int SUB_W   = 32,
  parameter int NWORDS  = 192
) (
  input logic               clk,
  input logic               rst_n,
  input logic               accept,
  input logic               wr_busy,
  input logic [WADDR_W-1:0] wr_addr,
  input logic               we_lo,
  input logic               we_hi,
  input logic [ROW_W-1:0]   wr_row,
  input logic               rd_req,
  input logic [RIDX_W-1:0]  rd_idx,
  input logic               rd_valid,
  input logic [SUB_W-1:0]   rd_data
);
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wr_busy);
  a_r1_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |=> !wr_busy);
  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !wr_busy) |-> (!we_lo && !we_hi));
  a_r2_even_first: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wr_addr[0]) |-> (we_lo && we_hi));
  a_r3_odd_first: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_addr[0]) |-> (!we_lo && we_hi));
  a_r2_even_second: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wr_addr[0]) |=> (we_lo && !we_hi));
  a_r3_odd_second: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_addr[0]) |=> (we_lo && we_hi));
  a_r5_next_row: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (wr_row == ROW_W'($past(wr_row) + 1'b1)));
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  a_r8_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && 32'(rd_idx) >= 32'(NWORDS)) |=> (rd_data == '0));
endmodule

bind packed_wide_buffer pwb_checker #(
  .WADDR_W(WADDR_W), .ROW_W(ROW_W), .RIDX_W(RIDX_W), .SUB_W(SUB_W), .NWORDS(NWORDS)
) u_pwb_checker (
  .clk(clk), .rst_n(rst_n), .accept(accept), .wr_busy(wr_busy),
  .wr_addr(wr_addr), .we_lo(we_lo), .we_hi(we_hi), .wr_row(wr_row),
  .rd_req(rd_req), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/packed_wide_buffer_tb_top.sv
module packed_wide_buffer_tb_top;
  localparam int SUB_W   = 32;
  localparam int WADDR_W = 6;
  localparam int NREC    = 2 ** WADDR_W;
  localparam int NWORDS  = 3 * NREC;
  localparam int RIDX_W  = $clog2(NWORDS);

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 wr_req;
  logic [WADDR_W-1:0]   wr_addr;
  logic [3*SUB_W-1:0]   wr_data;
  logic                 wr_busy;
  logic                 rd_req;
  logic [RIDX_W-1:0]    rd_idx;
  logic                 rd_valid;
  logic [SUB_W-1:0]     rd_data;

  logic [3*SUB_W-1:0] model [NREC];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  packed_wide_buffer #(.SUB_W(SUB_W), .WADDR_W(WADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_busy(wr_busy), .rd_req(rd_req), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [SUB_W-1:0] expect_word(input int k);
    int rec = k / 3;
    int sub = k % 3;
    return model[rec][sub*SUB_W +: SUB_W];
  endfunction

  function automatic logic [3*SUB_W-1:0] rand_rec();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [SUB_W-1:0] act, input logic [SUB_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [3*SUB_W-1:0] d);
    @(negedge clk);
    wr_req  = 1'b1;
    wr_addr = WADDR_W'(a);
    wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    check(wr_busy == 1'b1, "R1 busy in second cycle", SUB_W'(wr_busy), 1);
    model[a] = d;
  endtask

  task automatic do_read(input int k, input string tag);
    logic [SUB_W-1:0] exp;
    @(negedge clk);
    rd_req = 1'b1;
    rd_idx = RIDX_W'(k);
    @(negedge clk);
    rd_req = 1'b0;
    exp = (k < NWORDS) ? expect_word(k) : '0;
    check(rd_valid == 1'b1, "R6 valid after read", SUB_W'(rd_valid), 1);
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [SUB_W-1:0]   old0, old2;
    logic [3*SUB_W-1:0] nd;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; wr_req = 1'b0; wr_addr = '0; wr_data = '0;
    rd_req = 1'b0; rd_idx = '0;
    repeat (3) @(negedge clk);
    // R9: reset values
    check(wr_busy == 1'b0, "R9 busy in reset", SUB_W'(wr_busy), 0);
    check(rd_valid == 1'b0, "R9 valid in reset", SUB_W'(rd_valid), 0);
    check(rd_data == '0, "R9 data in reset", rd_data, 0);
    rst_n = 1'b1;

    // Fill every record, then read every word
    for (int a = 0; a < NREC; a++) do_write(a, rand_rec());
    for (int k = 0; k < NWORDS; k++)
      do_read(k, ((k / 3) % 2 == 0) ? "R2 R4 even record word" : "R3 R4 odd record word");

    // R6: no read request, no valid
    @(negedge clk);
    check(rd_valid == 1'b0, "R6 valid low when idle", SUB_W'(rd_valid), 0);

    // R1: request held through busy cycle is ignored
    nd = rand_rec();
    @(negedge clk);
    wr_req = 1'b1; wr_addr = 6'd5; wr_data = nd;
    @(negedge clk);
    check(wr_busy == 1'b1, "R1 busy after accept", SUB_W'(wr_busy), 1);
    wr_addr = 6'd6; wr_data = rand_rec();
    @(negedge clk);
    wr_req = 1'b0;
    check(wr_busy == 1'b0, "R1 busy drops", SUB_W'(wr_busy), 0);
    model[5] = nd;
    for (int k = 15; k < 21; k++) do_read(k, "R1 ignored request left record intact");

    // R5: shared row between record 2 (even) and record 3 (odd)
    do_write(3, rand_rec());
    do_read(8, "R5 even neighbour sub-word 2 kept");
    do_write(2, rand_rec());
    do_read(9, "R5 odd neighbour sub-word 0 kept");
    for (int k = 6; k < 12; k++) do_read(k, "R5 pair contents");

    // R7: read during write, even (10) and odd (11) records
    for (int a = 10; a < 12; a++) begin
      old0 = expect_word(3 * a);
      old2 = expect_word(3 * a + 2);
      nd = rand_rec();
      @(negedge clk);
      wr_req = 1'b1; wr_addr = WADDR_W'(a); wr_data = nd;
      rd_req = 1'b1; rd_idx = RIDX_W'(3 * a);
      @(negedge clk);
      wr_req = 1'b0;
      rd_idx = RIDX_W'(3 * a + 2);
      check(rd_data == old0, "R7 old data in accept cycle", rd_data, old0);
      @(negedge clk);
      rd_req = 1'b0;
      check(rd_data == old2, "R7 old data in second cycle", rd_data, old2);
      model[a] = nd;
      for (int s = 0; s < 3; s++) do_read(3 * a + s, "R7 new data afterwards");
    end

    // R8: out-of-range indices
    do_read(NWORDS, "R8 first index past end reads zero");
    do_read(2 ** RIDX_W - 1, "R8 last index reads zero");

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 2) == 0) do_write($urandom_range(0, NREC - 1), rand_rec());
      else do_read($urandom_range(0, NWORDS - 1), "R4 random read");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule